// File: doc/BRIEF.md
# Timer host register interface

This block is the bus-facing front end of a three-channel interval timer. A host drives an 8-bit write data bus, a 2-bit address and three active-low strobes (chip select, read, write). The block decides which of four targets an access reaches: one of the three counter channels, or the control port. It then turns the access into single-cycle events toward the counting logic. Those events are a configuration change (operating mode, BCD flag, byte access type), a freshly assembled 16-bit count to load, or a freeze of the running count for a consistent readout.

Sixteen-bit quantities cross the 8-bit bus as one or two bytes, as the channel's programmed access type selects. Each channel keeps its own write and read byte pointers and a staging byte for the low half of a count. The counting logic sits outside this block. It supplies each channel's live count on an input vector and receives the mode, the BCD flag, the configuration strobe and the load strobe and value. Read data leaves on its own output port, and no tri-state bus is used.

Top module: `tmr_host_if`

## Requirements
- R1: Address 0, 1 and 2 select channel 0, 1 and 2. Address 3 selects the control port. A data write to channel n changes only channel n's load outputs.
- R2: A write is taken once per access, at the first clock edge where the qualified write condition (cs_n low, wr_n low, rd_n high) is no longer present. The address and data are those last seen while the write condition held. The resulting load_stb or cfg_stb bit is high for exactly one cycle, starting after that edge, however long the strobe was held.
- R3: An access with cs_n high, or with rd_n and wr_n both high, or with rd_n and wr_n both low, changes no state. dout is 0 whenever no qualified read (cs_n low, rd_n low, wr_n high) is in progress.
- R4: The byte written to address 3 is decoded as follows. Bits 7:6 select the channel. Bits 5:4 give the access type. Bits 3:1 give the mode and bit 0 the BCD flag. With a non-zero access type, the named channel takes the mode, BCD flag and access type and pulses cfg_stb. Channel select 3 is ignored.
- R5: Access type 01 loads after a single write, with the byte as the low half and 0 as the high half. Access type 10 loads after a single write, with the byte as the high half and 0 as the low half.
- R6: Access type 11 takes the low byte and then the high byte. The load happens only when the high byte is written. A control word that configures the channel returns its write pointer to the low byte.
- R7: A read of a channel returns a byte of its count, chosen by the access type: 01 gives the low byte, 10 the high byte, and 11 alternates low then high. The read pointer advances when the read access ends.
- R8: Access type 00 is a latch command. It freezes the channel's current count without touching the mode. Reads return the frozen value until the final byte for the access type has been read, after which they follow the live count again. A second latch command while a value is frozen has no effect.
- R9: A read at address 3 returns 0 and leaves every channel's read pointer and latch unchanged.
- R10: After reset every channel has access type 11, mode 0, BCD 0, both pointers on the low byte and no frozen value. All strobes are low and every load value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; strobes are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Target select: channels 0 to 2, control port 3 |
| din | input | 8 | Write data from the host |
| dout | output | 8 | Read data to the host, 0 when not reading |
| cnt_in | input | 48 | Live count of each channel, channel n in bits 16n+15:16n |
| mode_o | output | 9 | Programmed mode, channel n in bits 3n+2:3n |
| bcd_o | output | 3 | Programmed BCD flag per channel |
| cfg_stb | output | 3 | One-cycle pulse per channel on a configuring control word |
| load_stb | output | 3 | One-cycle pulse per channel when a complete count is loaded |
| load_val | output | 48 | Last loaded count per channel, channel n in bits 16n+15:16n |

## Verification
The hardest state to reach is a frozen count in two-byte mode while the live count moves underneath it, with the read pointer part-way through the pair. A control word that lands between the two bytes of a count is nearly as hard. The stimulus latches a channel, changes its live count and reads the pair. It then reads a third time to see the live value return. It also breaks a low/high write pair with a new control word and checks that the next pair is assembled from scratch. A behavioural model in the bench tracks pointers, staging bytes and frozen values and is compared against every output on every clock.

// File: rtl/tmr_host_pkg.sv
package tmr_host_pkg;

    localparam int DW  = 8;
    localparam int CW  = 2 * DW;
    localparam int NCH = 3;
    localparam int AW  = $clog2(NCH + 1);
    localparam int MW  = 3;
    localparam logic [AW-1:0] CTRL_ADDR = AW'(NCH);

    typedef enum logic [1:0] {
        ACC_LATCH = 2'b00,
        ACC_LO    = 2'b01,
        ACC_HI    = 2'b10,
        ACC_BOTH  = 2'b11
    } acc_e;

    typedef struct packed {
        logic [1:0]    sel;
        acc_e          acc;
        logic [MW-1:0] mode;
        logic          bcd;
    } ctrl_word_t;

    typedef struct packed {
        logic          vld;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } bus_evt_t;

    function automatic logic last_byte(acc_e a, logic ptr);
        return (a != ACC_BOTH) || ptr;
    endfunction

    function automatic logic [DW-1:0] pick_byte(acc_e a, logic ptr, logic [CW-1:0] v);
        if (a == ACC_HI || (a == ACC_BOTH && ptr))
            return v[CW-1:DW];
        return v[DW-1:0];
    endfunction

endpackage

// File: rtl/tmr_host_strobe.sv
module tmr_host_strobe
    import tmr_host_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output bus_evt_t      wr_evt,
    output bus_evt_t      rd_evt,
    output logic          rd_live
);

    logic          wr_now, rd_now;
    logic          wr_q, rd_q;
    logic [AW-1:0] wa_q, ra_q;
    logic [DW-1:0] wd_q;

    assign wr_now  = !cs_n && !wr_n && rd_n;
    assign rd_now  = !cs_n && !rd_n && wr_n;
    assign rd_live = rd_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q <= 1'b0;
            rd_q <= 1'b0;
            wa_q <= '0;
            wd_q <= '0;
            ra_q <= '0;
        end else begin
            wr_q <= wr_now;
            rd_q <= rd_now;
            if (wr_now) begin
                wa_q <= addr;
                wd_q <= din;
            end
            if (rd_now)
                ra_q <= addr;
        end
    end

    always_comb begin
        wr_evt.vld  = wr_q && !wr_now;
        wr_evt.addr = wa_q;
        wr_evt.data = wd_q;
        rd_evt.vld  = rd_q && !rd_now;
        rd_evt.addr = ra_q;
        rd_evt.data = '0;
    end

    // R2: an access ends once, so an end event never repeats on the next edge
    p_single_commit_r2: assert property (@(posedge clk) disable iff (rst)
        wr_evt.vld |=> !wr_evt.vld);

    // R3: a read end and a write end never coincide
    p_evt_excl_r3: assert property (@(posedge clk) disable iff (rst)
        !(wr_evt.vld && rd_evt.vld));

endmodule

// File: rtl/tmr_host_chan.sv
module tmr_host_chan
    import tmr_host_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          cw_vld,
    input  ctrl_word_t    cw,
    input  logic          wr_vld,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_done,
    input  logic [CW-1:0] cnt_in,
    output logic [MW-1:0] mode_o,
    output logic          bcd_o,
    output logic          cfg_stb_o,
    output logic          load_stb_o,
    output logic [CW-1:0] load_val_o,
    output logic [DW-1:0] rd_byte
);

    acc_e          acc;
    logic          wptr, rptr;
    logic [DW-1:0] lo_stage;
    logic          latched;
    logic [CW-1:0] lval;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc        <= ACC_BOTH;
            mode_o     <= '0;
            bcd_o      <= 1'b0;
            wptr       <= 1'b0;
            rptr       <= 1'b0;
            lo_stage   <= '0;
            latched    <= 1'b0;
            lval       <= '0;
            cfg_stb_o  <= 1'b0;
            load_stb_o <= 1'b0;
            load_val_o <= '0;
        end else begin
            cfg_stb_o  <= 1'b0;
            load_stb_o <= 1'b0;
            if (cw_vld) begin
                if (cw.acc == ACC_LATCH) begin
                    if (!latched) begin
                        latched <= 1'b1;
                        lval    <= cnt_in;
                    end
                end else begin
                    acc       <= cw.acc;
                    mode_o    <= cw.mode;
                    bcd_o     <= cw.bcd;
                    wptr      <= 1'b0;
                    rptr      <= 1'b0;
                    latched   <= 1'b0;
                    cfg_stb_o <= 1'b1;
                end
            end
            if (wr_vld) begin
                case (acc)
                    ACC_LO: begin
                        load_val_o <= {{DW{1'b0}}, wr_data};
                        load_stb_o <= 1'b1;
                    end
                    ACC_HI: begin
                        load_val_o <= {wr_data, {DW{1'b0}}};
                        load_stb_o <= 1'b1;
                    end
                    ACC_BOTH: begin
                        if (!wptr) begin
                            lo_stage <= wr_data;
                            wptr     <= 1'b1;
                        end else begin
                            load_val_o <= {wr_data, lo_stage};
                            load_stb_o <= 1'b1;
                            wptr       <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
            if (rd_done) begin
                if (acc == ACC_BOTH)
                    rptr <= !rptr;
                if (last_byte(acc, rptr))
                    latched <= 1'b0;
            end
        end
    end

    assign rd_byte = pick_byte(acc, rptr, latched ? lval : cnt_in);

    // R6: a two-byte load leaves the write pointer back on the low byte
    p_load_after_high_r6: assert property (@(posedge clk) disable iff (rst)
        (load_stb_o && acc == ACC_BOTH) |-> !wptr);

    // R6: a configuring control word clears both pointers and any frozen value
    p_cfg_resets_ptr_r6: assert property (@(posedge clk) disable iff (rst)
        cfg_stb_o |-> (!wptr && !rptr && !latched));

    // R8: a frozen value stays put while it remains frozen
    p_latch_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        (latched && $past(latched)) |-> $stable(lval));

endmodule

// File: rtl/tmr_host_if.sv
module tmr_host_if
    import tmr_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     din,
    output logic [DW-1:0]     dout,
    input  logic [NCH*CW-1:0] cnt_in,
    output logic [NCH*MW-1:0] mode_o,
    output logic [NCH-1:0]    bcd_o,
    output logic [NCH-1:0]    cfg_stb,
    output logic [NCH-1:0]    load_stb,
    output logic [NCH*CW-1:0] load_val
);

    bus_evt_t      wr_evt, rd_evt;
    logic          rd_live;
    ctrl_word_t    cw;
    logic          is_ctrl;
    logic [DW-1:0] rd_byte [NCH];

    tmr_host_strobe u_strobe (
        .clk     (clk),
        .rst     (rst),
        .cs_n    (cs_n),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .addr    (addr),
        .din     (din),
        .wr_evt  (wr_evt),
        .rd_evt  (rd_evt),
        .rd_live (rd_live)
    );

    assign cw      = ctrl_word_t'(wr_evt.data);
    assign is_ctrl = wr_evt.vld && (wr_evt.addr == CTRL_ADDR);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic cw_hit, wr_hit, rd_hit;
        assign cw_hit = is_ctrl && (cw.sel == 2'(g));
        assign wr_hit = wr_evt.vld && (wr_evt.addr == AW'(g));
        assign rd_hit = rd_evt.vld && (rd_evt.addr == AW'(g));

        tmr_host_chan u_chan (
            .clk        (clk),
            .rst        (rst),
            .cw_vld     (cw_hit),
            .cw         (cw),
            .wr_vld     (wr_hit),
            .wr_data    (wr_evt.data),
            .rd_done    (rd_hit),
            .cnt_in     (cnt_in[g*CW +: CW]),
            .mode_o     (mode_o[g*MW +: MW]),
            .bcd_o      (bcd_o[g]),
            .cfg_stb_o  (cfg_stb[g]),
            .load_stb_o (load_stb[g]),
            .load_val_o (load_val[g*CW +: CW]),
            .rd_byte    (rd_byte[g])
        );
    end

    always_comb begin
        dout = '0;
        if (rd_live) begin
            for (int i = 0; i < NCH; i++) begin
                if (addr == AW'(i))
                    dout = rd_byte[i];
            end
        end
    end

    // R2: at most one channel loads or is configured per cycle
    p_one_load_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(load_stb) && $onehot0(cfg_stb));

    // R3: deselected bus drives zero
    p_idle_dout_r3: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> (dout == '0));

    // R9: reads of the control port return zero
    p_ctrl_read_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !rd_n && wr_n && addr == CTRL_ADDR) |-> (dout == '0));

    // R4: a control word never both configures and loads in the same cycle
    p_cfg_load_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(|cfg_stb && |load_stb));

endmodule

// File: tb/sim_tmr_host_if.sv
`timescale 1ns/1ps
module sim_tmr_host_if;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0]  addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic [47:0] cnt_in = '0;
    logic [8:0]  mode_o;
    logic [2:0]  bcd_o, cfg_stb, load_stb;
    logic [47:0] load_val;

    int checks = 0;
    int errors = 0;
    int nload  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    tmr_host_if u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .din(din), .dout(dout), .cnt_in(cnt_in),
        .mode_o(mode_o), .bcd_o(bcd_o), .cfg_stb(cfg_stb),
        .load_stb(load_stb), .load_val(load_val)
    );

    // behavioural reference state
    int m_acc[3], m_mode[3], m_bcd[3], m_wp[3], m_rp[3], m_lo[3], m_lat[3], m_lv[3];
    int e_val[3];
    bit e_ld[3], e_cfg[3];
    bit pw, pr;
    int pw_a, pw_d, pr_a;

    function automatic int live(int c);
        return int'(cnt_in[c*16 +: 16]);
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic m_write(int a, int d);
        int s, ac;
        if (a == 3) begin
            s  = (d >> 6) & 3;
            ac = (d >> 4) & 3;
            if (s < 3) begin
                if (ac == 0) begin
                    if (m_lat[s] == 0) begin m_lat[s] = 1; m_lv[s] = live(s); end
                end else begin
                    m_acc[s] = ac; m_mode[s] = (d >> 1) & 7; m_bcd[s] = d & 1;
                    m_wp[s] = 0; m_rp[s] = 0; m_lat[s] = 0; e_cfg[s] = 1;
                end
            end
        end else if (m_acc[a] == 1) begin
            e_val[a] = d; e_ld[a] = 1;
        end else if (m_acc[a] == 2) begin
            e_val[a] = d << 8; e_ld[a] = 1;
        end else if (m_wp[a] == 0) begin
            m_lo[a] = d; m_wp[a] = 1;
        end else begin
            e_val[a] = (d << 8) | m_lo[a]; e_ld[a] = 1; m_wp[a] = 0;
        end
    endtask

    task automatic m_read(int a);
        bit fin;
        if (a < 3) begin
            fin = (m_acc[a] != 3) || (m_rp[a] == 1);
            if (m_acc[a] == 3) m_rp[a] ^= 1;
            if (fin) m_lat[a] = 0;
        end
    endtask

    function automatic int m_dout();
        int a, v;
        bit hi;
        a = int'(addr);
        if (cs_n || rd_n || !wr_n || a == 3) return 0;
        v  = m_lat[a] ? m_lv[a] : live(a);
        hi = (m_acc[a] == 2) || (m_acc[a] == 3 && m_rp[a] == 1);
        return hi ? ((v >> 8) & 255) : (v & 255);
    endfunction

    always @(posedge clk) begin
        bit wn, rn;
        wn = !cs_n && !wr_n && rd_n;
        rn = !cs_n && !rd_n && wr_n;
        if (rst) begin
            for (int c = 0; c < 3; c++) begin
                m_acc[c] = 3; m_mode[c] = 0; m_bcd[c] = 0; m_wp[c] = 0; m_rp[c] = 0;
                m_lo[c] = 0; m_lat[c] = 0; m_lv[c] = 0; e_val[c] = 0; e_ld[c] = 0; e_cfg[c] = 0;
            end
            pw = 0; pr = 0;
        end else begin
            for (int c = 0; c < 3; c++) begin e_ld[c] = 0; e_cfg[c] = 0; end
            if (pw && !wn) m_write(pw_a, pw_d);
            if (pr && !rn) m_read(pr_a);
            pw = wn; pr = rn;
            if (wn) begin pw_a = int'(addr); pw_d = int'(din); end
            if (rn) pr_a = int'(addr);
        end
    end

    // cycle-by-cycle comparison against the reference
    always @(negedge clk) begin
        if (!rst && !done) begin
            nload += $countones(load_stb);
            for (int c = 0; c < 3; c++) begin
                chk("R5/R6 load_stb", int'(load_stb[c]), int'(e_ld[c]));
                chk("R5/R6 load_val", int'(load_val[c*16 +: 16]), e_val[c]);
                chk("R4 cfg_stb", int'(cfg_stb[c]), int'(e_cfg[c]));
                chk("R4 mode", int'(mode_o[c*3 +: 3]), m_mode[c]);
                chk("R4 bcd", int'(bcd_o[c]), m_bcd[c]);
            end
            chk("R7 dout", int'(dout), m_dout());
        end
    end

    task automatic bus_wr(int a, int d, int hold = 1);
        @(negedge clk); cs_n = 0; addr = 2'(a); din = 8'(d); wr_n = 0;
        repeat (hold) @(negedge clk);
        wr_n = 1;
        @(negedge clk); cs_n = 1;
        @(negedge clk);
    endtask

    task automatic bus_rd(int a, output int v);
        @(negedge clk); cs_n = 0; addr = 2'(a); rd_n = 0;
        @(negedge clk); v = int'(dout);
        rd_n = 1;
        @(negedge clk); cs_n = 1;
        @(negedge clk);
    endtask

    function automatic int lv(int c);
        return int'(load_val[c*16 +: 16]);
    endfunction

    initial begin
        int v;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R10: reset state
        chk("R10 mode", int'(mode_o), 0);
        chk("R10 strobes", int'({cfg_stb, load_stb}), 0);
        chk("R10 load_val", int'(load_val[31:0]), 0);
        chk("R10 dout", int'(dout), 0);

        // R4: ch0, access 11, mode 2
        bus_wr(3, 8'h34);
        chk("R4 mode ch0", int'(mode_o[2:0]), 2);
        // R6: low byte alone does not load
        bus_wr(0, 8'h34);
        chk("R6 no load after low", lv(0), 0);
        bus_wr(0, 8'h12);
        chk("R6 pair", lv(0), 16'h1234);

        // R5: ch1 low only, ch2 high only with BCD
        bus_wr(3, 8'h52);
        bus_wr(1, 8'hAB);
        chk("R5 low only", lv(1), 16'h00AB);
        bus_wr(3, 8'hA7);
        chk("R4 bcd ch2", int'(bcd_o[2]), 1);
        chk("R4 mode ch2", int'(mode_o[8:6]), 3);
        bus_wr(2, 8'hCD);
        chk("R5 high only", lv(2), 16'hCD00);
        // R1: other channels untouched
        chk("R1 ch0 kept", lv(0), 16'h1234);
        chk("R1 ch1 kept", lv(1), 16'h00AB);

        // R4: select 3 ignored
        bus_wr(3, 8'hF6);
        chk("R4 sel3 modes", int'(mode_o), {3'd3, 3'd1, 3'd2});

        // R7: two-byte reads alternate
        cnt_in[15:0] = 16'hBEEF;
        bus_rd(0, v); chk("R7 low first", v, 8'hEF);
        bus_rd(0, v); chk("R7 high second", v, 8'hBE);
        // R9: control read returns 0, pointer untouched
        bus_rd(3, v); chk("R9 ctrl read", v, 0);
        bus_rd(0, v); chk("R9 ptr kept", v, 8'hEF);
        bus_rd(0, v);

        // R8: latch ch0 then change live count
        bus_wr(3, 8'h00);
        cnt_in[15:0] = 16'h1177;
        chk("R8 mode kept", int'(mode_o[2:0]), 2);
        bus_rd(0, v); chk("R8 frozen low", v, 8'hEF);
        bus_wr(3, 8'h00);
        bus_rd(0, v); chk("R8 frozen high", v, 8'hBE);
        bus_rd(0, v); chk("R8 released", v, 8'h77);
        bus_rd(0, v);
        // R8: ch1 low-only latch released after one byte
        cnt_in[31:16] = 16'h0042;
        bus_wr(3, 8'h40);
        cnt_in[31:16] = 16'h0099;
        bus_rd(1, v); chk("R8 ch1 frozen", v, 8'h42);
        bus_rd(1, v); chk("R8 ch1 live", v, 8'h99);

        // R6: control word mid-pair restarts the pair
        bus_wr(0, 8'h11);
        bus_wr(3, 8'h30);
        bus_wr(0, 8'h55);
        chk("R6 mid-pair no load", lv(0), 16'h1234);
        bus_wr(0, 8'h66);
        chk("R6 restarted pair", lv(0), 16'h6655);

        // R3: deselected write and double-strobe write ignored
        @(negedge clk); cs_n = 1; addr = 2'd1; din = 8'h77; wr_n = 0;
        @(negedge clk); wr_n = 1;
        @(negedge clk); cs_n = 0; rd_n = 0; wr_n = 0;
        @(negedge clk); rd_n = 1; wr_n = 1; cs_n = 1;
        chk("R3 dout both low", int'(dout), 0);
        repeat (2) @(negedge clk);
        chk("R3 ignored writes", lv(1), 16'h00AB);

        // R2: long strobe gives one load
        nload = 0;
        bus_wr(1, 8'h5A, 12);
        chk("R2 one load", nload, 1);
        chk("R2 value", lv(1), 16'h005A);

        repeat (4) @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog act=running exp=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule